// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the digital divider pair of a frequency synthesizer loop. The feedback path divides a fast input clock by N = B·P + A. A behavioural dual-modulus prescaler divides by P or by P+1. A swallow counter (A) and a main counter (B) steer the prescaler's modulus. For the first A prescaler cycles of each output period the prescaler divides by P+1. For the remaining B−A cycles it divides by P. After B prescaler cycles in total, the period ends. A separate reference divider divides the same clock by R. Both dividers mark the end of each period with a pulse one clock wide.

The programmed values can change at any time, but each divider samples them only at its own period boundary. A period that is already running keeps the values it started with. Programmed values that cannot form a valid division are not used for output. If B is below A or below three, the feedback pulses stop. If R is zero, the reference pulses stop. In both cases a shared error flag rises.

Top module: `swd_divider`

## Requirements
- R1: While `rst_n` is low, `fb_pulse` and `ref_pulse` are low and `cfg_err` is high.
- R2: With a legal setting (B ≥ A, B ≥ 3), consecutive `fb_pulse` assertions are exactly B·P + A clock cycles apart, and each pulse lasts one cycle.
- R3: The prescaler modulus P is chosen by `pre_sel`: 0 gives 8, 1 gives 16, 2 gives 32 and 3 gives 64.
- R4: The swallow value A may take any value from 0 up to min(B, 63). This includes A = 0 (every prescaler cycle divides by P) and A = B (every prescaler cycle divides by P+1).
- R5: With R between 1 and 16383, consecutive `ref_pulse` assertions are exactly R cycles apart. R = 1 gives a pulse on every cycle.
- R6: A change to A, B, `pre_sel` or R that is made during a period does not alter that period. It takes effect from the following period.
- R7: Once a setting with B < A or B < 3 has been taken up at a boundary, `cfg_err` is high and `fb_pulse` stays low. The period that was already running still ends with its pulse.
- R8: A zero value of B or of R is illegal. Once R = 0 has been taken up, `cfg_err` is high and `ref_pulse` stays low.
- R9: When legal values are restored, the divider takes them up within one prescaler cycle. `cfg_err` then falls, and pulses resume at the new interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-rate input clock (the divided signal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_sel | input | 2 | Prescaler modulus select: 0→8/9, 1→16/17, 2→32/33, 3→64/65 |
| swallow_val | input | 6 | Swallow count A |
| main_val | input | 13 | Main count B |
| ref_val | input | 14 | Reference division ratio R |
| fb_pulse | output | 1 | One-cycle pulse per feedback period |
| ref_pulse | output | 1 | One-cycle pulse per reference period |
| cfg_err | output | 1 | High while an illegal feedback or reference setting is in use |

## Verification
The assertions assume a legal feedback setting never produces a period shorter than three prescaler cycles of the smallest modulus. They also assume the pulse checks may treat the active legality of each divider as ground truth. The stimulus respects these assumptions. Random settings keep B between 3 and 52 and draw A no larger than B. Illegal settings are applied only in directed steps. Inputs change only on the falling edge right after an observed pulse. This makes it possible to predict which period sees old values and which sees new ones.

// File: rtl/swd_pkg.sv
package swd_pkg;
   // smallest main count that still gives the swallow logic room to act
   localparam int unsigned MIN_MAIN = 3;

   typedef enum logic [1:0] {
      PRE_DIV8  = 2'd0,
      PRE_DIV16 = 2'd1,
      PRE_DIV32 = 2'd2,
      PRE_DIV64 = 2'd3
   } pre_sel_e;
endpackage

// File: rtl/swd_prescaler.sv
// Behavioural dual-modulus stage: counts down from the value supplied at
// each terminal count; the stage lasts (ld_val + 1) input cycles.
module swd_prescaler #(
   parameter int unsigned PC_W = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] ld_val,
   output logic            tick
);
   logic [PC_W-1:0] pcnt;

   assign tick = (pcnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt <= '0;
      end else if (tick) begin
         pcnt <= ld_val;
      end else begin
         pcnt <= pcnt - PC_W'(1);
      end
   end
endmodule

// File: rtl/swd_swallow_ctrl.sv
// Swallow (A) and main (B) counters; chooses the modulus of every prescaler
// cycle and captures new settings only at a period boundary.
module swd_swallow_ctrl #(
   parameter int unsigned A_W         = 6,
   parameter int unsigned B_W         = 13,
   parameter int unsigned SEL_W       = 2,
   parameter int unsigned PRE_LOG_MIN = 3,
   parameter int unsigned PC_W        = PRE_LOG_MIN + (1 << SEL_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [SEL_W-1:0] sel_in,
   input  logic [A_W-1:0]   a_in,
   input  logic [B_W-1:0]   b_in,
   output logic [PC_W-1:0]  ld_val,
   output logic             fire,
   output logic             ok
);
   localparam int unsigned N_SEL = 1 << SEL_W;

   logic [PC_W-1:0]  p_lut [N_SEL];
   logic [A_W-1:0]   a_cnt, a_nx;
   logic [B_W-1:0]   b_cnt;
   logic [SEL_W-1:0] sel_act;
   logic             ok_act, ok_new, bound;
   logic [PC_W-1:0]  p_use;

   // modulus table: P = 2^(PRE_LOG_MIN + sel)
   for (genvar g = 0; g < N_SEL; g++) begin : g_lut
      assign p_lut[g] = PC_W'(1) << (PRE_LOG_MIN + g);
   end

   assign ok_new = (b_in >= B_W'(a_in)) && (b_in >= B_W'(swd_pkg::MIN_MAIN));
   // an illegal active setting ends every prescaler cycle so recovery is quick
   assign bound  = tick && ((b_cnt == B_W'(1)) || !ok_act);
   assign fire   = bound && ok_act;
   assign ok     = ok_act;

   always_comb begin
      if (bound) begin
         a_nx  = a_in;
         p_use = p_lut[sel_in];
      end else begin
         a_nx  = (a_cnt != '0) ? (a_cnt - A_W'(1)) : a_cnt;
         p_use = p_lut[sel_act];
      end
      // a pending swallow stretches the next prescaler cycle to P+1
      ld_val = (a_nx != '0) ? p_use : (p_use - PC_W'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_cnt   <= '0;
         b_cnt   <= '0;
         sel_act <= '0;
         ok_act  <= 1'b0;
      end else if (tick) begin
         a_cnt <= a_nx;
         if (bound) begin
            b_cnt   <= b_in;
            sel_act <= sel_in;
            ok_act  <= ok_new;
         end else begin
            b_cnt <= b_cnt - B_W'(1);
         end
      end
   end
endmodule

// File: rtl/swd_ref_div.sv
// Reference divider: period of R input cycles, R sampled at each boundary.
module swd_ref_div #(
   parameter int unsigned R_W = 14
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [R_W-1:0] r_in,
   output logic           fire,
   output logic           ok
);
   logic [R_W-1:0] r_act, rcnt;
   logic           bound;

   assign ok    = (r_act != '0);
   assign bound = (rcnt == '0) || !ok;
   assign fire  = bound && ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_act <= '0;
         rcnt  <= '0;
      end else if (bound) begin
         r_act <= r_in;
         rcnt  <= r_in - R_W'(1);
      end else begin
         rcnt <= rcnt - R_W'(1);
      end
   end
endmodule

// File: rtl/swd_divider.sv
module swd_divider #(
   parameter int unsigned A_W         = 6,
   parameter int unsigned B_W         = 13,
   parameter int unsigned R_W         = 14,
   parameter int unsigned SEL_W       = 2,
   parameter int unsigned PRE_LOG_MIN = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] pre_sel,
   input  logic [A_W-1:0]   swallow_val,
   input  logic [B_W-1:0]   main_val,
   input  logic [R_W-1:0]   ref_val,
   output logic             fb_pulse,
   output logic             ref_pulse,
   output logic             cfg_err
);
   localparam int unsigned PC_W = PRE_LOG_MIN + (1 << SEL_W);

   // elaboration-time parameter checks
   if (B_W < A_W) begin : g_bad_ab
      $error("main counter narrower than swallow counter");
   end
   if (B_W < 2 || R_W < 1 || SEL_W < 1) begin : g_bad_w
      $error("divider widths too small");
   end
   if (PC_W > 16) begin : g_bad_p
      $error("prescaler modulus range too large");
   end

   logic [PC_W-1:0] ld_val;
   logic            tick, fb_fire, fb_ok, ref_fire, ref_ok;

   swd_prescaler #(.PC_W(PC_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld_val (ld_val),
      .tick   (tick)
   );

   swd_swallow_ctrl #(
      .A_W         (A_W),
      .B_W         (B_W),
      .SEL_W       (SEL_W),
      .PRE_LOG_MIN (PRE_LOG_MIN),
      .PC_W        (PC_W)
   ) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .sel_in (pre_sel),
      .a_in   (swallow_val),
      .b_in   (main_val),
      .ld_val (ld_val),
      .fire   (fb_fire),
      .ok     (fb_ok)
   );

   swd_ref_div #(.R_W(R_W)) u_ref (
      .clk   (clk),
      .rst_n (rst_n),
      .r_in  (ref_val),
      .fire  (ref_fire),
      .ok    (ref_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fb_pulse  <= 1'b0;
         ref_pulse <= 1'b0;
      end else begin
         fb_pulse  <= fb_fire;
         ref_pulse <= ref_fire;
      end
   end

   assign cfg_err = !fb_ok || !ref_ok;
endmodule

// File: rtl/swd_divider_chk.sv
module swd_divider_chk #(
   parameter int unsigned PRE_LOG_MIN = 3
) (
   input logic clk,
   input logic rst_n,
   input logic fb_pulse,
   input logic ref_pulse,
   input logic fb_ok,
   input logic ref_ok
);
   localparam int unsigned MIN_GAP = 3 * (1 << PRE_LOG_MIN) - 1;

   logic [15:0] gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap <= '0;
      end else if (fb_pulse) begin
         gap <= '0;
      end else if (gap != '1) begin
         gap <= gap + 16'd1;
      end
   end

   // R1
   always @(posedge clk) begin
      if (!rst_n) begin
         reset_quiet_chk: assert (!fb_pulse && !ref_pulse && !fb_ok && !ref_ok);
      end
   end

   // R2
   fb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fb_pulse |=> !fb_pulse);

   // R2
   fb_min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fb_pulse |-> (gap >= 16'(MIN_GAP)));

   // R7
   fb_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fb_ok && $past(!fb_ok)) |-> !fb_pulse);

   // R8
   ref_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ref_ok && $past(!ref_ok)) |-> !ref_pulse);
endmodule

bind swd_divider swd_divider_chk #(.PRE_LOG_MIN(PRE_LOG_MIN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fb_pulse  (fb_pulse),
   .ref_pulse (ref_pulse),
   .fb_ok     (fb_ok),
   .ref_ok    (ref_ok)
);

// File: tb/swd_divider_bench.sv
`timescale 1ns/1ps
module swd_divider_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  pre_sel;
   logic [5:0]  swallow_val;
   logic [12:0] main_val;
   logic [13:0] ref_val;
   logic        fb_pulse, ref_pulse, cfg_err;

   int total = 0;
   int bad   = 0;
   int cyc_count = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   swd_divider u_swd_divider (
      .clk         (clk),
      .rst_n       (rst_n),
      .pre_sel     (pre_sel),
      .swallow_val (swallow_val),
      .main_val    (main_val),
      .ref_val     (ref_val),
      .fb_pulse    (fb_pulse),
      .ref_pulse   (ref_pulse),
      .cfg_err     (cfg_err)
   );

   function automatic int exp_n(int a, int b, int ps);
      return b * (8 << ps) + a;
   endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_fb(output int c);
      c = 0;
      do begin
         @(negedge clk);
         c++;
      end while (!fb_pulse && c < 40000);
   endtask

   task automatic wait_ref(output int c);
      c = 0;
      do begin
         @(negedge clk);
         c++;
      end while (!ref_pulse && c < 40000);
   endtask

   // set a feedback setting right after a pulse; the running period keeps prev_n
   task automatic step_fb(int a, int b, int ps, inout int prev_n, input string tag);
      int c;
      swallow_val = 6'(a);
      main_val    = 13'(b);
      pre_sel     = 2'(ps);
      wait_fb(c);
      check(c == prev_n, "R6 running period kept", c, prev_n);
      wait_fb(c);
      check(c == exp_n(a, b, ps), tag, c, exp_n(a, b, ps));
      prev_n = exp_n(a, b, ps);
   endtask

   task automatic step_ref(int r, inout int prev_r);
      int c;
      ref_val = 14'(r);
      wait_ref(c);
      check(c == prev_r, "R6 reference period kept", c, prev_r);
      wait_ref(c);
      check(c == r, "R5 reference interval", c, r);
      prev_r = r;
   endtask

   task automatic quiet_fb(int len, string tag);
      int seen = 0;
      int errs = 0;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         if (fb_pulse) seen++;
         if (!cfg_err) errs++;
      end
      check(seen == 0, tag, seen, 0);
      check(errs == 0, "R7 cfg_err held", errs, 0);
   endtask

   initial begin : watchdog
      while (!done) begin
         @(posedge clk);
         cyc_count++;
         if (cyc_count > 195000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc_count, 195000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

   initial begin : stim
      int c, prev_n, prev_r, a, b, ps, seed_dummy;
      seed_dummy = $urandom(32'h5EED_0042);
      rst_n = 1'b1;
      pre_sel = 2'd0; swallow_val = 6'd0; main_val = 13'd3; ref_val = 14'd5;
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(fb_pulse == 1'b0, "R1 fb_pulse in reset", int'(fb_pulse), 0);
      check(ref_pulse == 1'b0, "R1 ref_pulse in reset", int'(ref_pulse), 0);
      check(cfg_err == 1'b1, "R1 cfg_err in reset", int'(cfg_err), 1);
      rst_n = 1'b1;

      wait_fb(c);
      prev_n = 24;
      // directed corners: R3 each select, R4 A=0 and A=B
      step_fb(3, 3, 0, prev_n, "R4 A equals B");
      step_fb(0, 3, 0, prev_n, "R4 A zero, minimum B");
      step_fb(5, 7, 1, prev_n, "R3 select 16");
      step_fb(0, 40, 2, prev_n, "R3 select 32");
      step_fb(63, 63, 3, prev_n, "R4 A at 63 with select 64");
      step_fb(17, 1000, 0, prev_n, "R2 large B");
      step_fb(1, 3, 3, prev_n, "R3 select 64");
      // constrained random: R2
      for (int k = 0; k < 10; k++) begin
         ps = int'($urandom % 4);
         b  = 3 + int'($urandom % 50);
         a  = int'($urandom % (b + 1));
         step_fb(a, b, ps, prev_n, "R2 random interval");
      end

      // R7: B < A
      swallow_val = 6'd10; main_val = 13'd5;
      wait_fb(c);
      check(c == prev_n, "R7 running period still pulses", c, prev_n);
      quiet_fb(400, "R7 no pulse with B below A");
      // R7: B < 3
      swallow_val = 6'd0; main_val = 13'd2;
      quiet_fb(200, "R7 no pulse with B below 3");
      // R8: B zero
      main_val = 13'd0;
      quiet_fb(200, "R8 no pulse with B zero");
      // R9 recovery
      swallow_val = 6'd2; main_val = 13'd4; pre_sel = 2'd0;
      wait_fb(c);
      check(cfg_err == 1'b0, "R9 cfg_err cleared", int'(cfg_err), 0);
      wait_fb(c);
      check(c == 34, "R9 interval after recovery", c, 34);

      // reference divider
      wait_ref(c);
      prev_r = 5;
      step_ref(1, prev_r);
      step_ref(2, prev_r);
      step_ref(7, prev_r);
      step_ref(16383, prev_r);
      step_ref(3, prev_r);

      // R8: R zero
      ref_val = 14'd0;
      wait_ref(c);
      check(c == prev_r, "R8 running reference period still pulses", c, prev_r);
      begin
         int seen = 0;
         int errs = 0;
         for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (ref_pulse) seen++;
            if (!cfg_err) errs++;
         end
         check(seen == 0, "R8 no reference pulse with R zero", seen, 0);
         check(errs == 0, "R8 cfg_err held for R zero", errs, 0);
      end
      ref_val = 14'd9;
      wait_ref(c);
      check(cfg_err == 1'b0, "R9 cfg_err cleared after R restored", int'(cfg_err), 0);
      wait_ref(c);
      check(c == 9, "R9 reference interval after recovery", c, 9);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule